// File: doc/BRIEF.md
# Three-Channel Control and Status Register Bank

This block is the register file for a three-channel data formatter. A bus master on a simple synchronous command bus issues idle, write and read commands, each with an 8-bit byte address and 32 bits of write data. The bank holds one read-write control register per channel. From these registers it drives that channel's enable, its two-bit priority, its three-bit packet-length code and the packet length decoded from that code. It also holds one read-only status word per channel, which reports the free space of that channel's FIFO as given on input ports.

Writes take effect on the clock edge of the write command. Reads are registered, so read data appears on the bus in the cycle after the read command. Reserved control bits, status addresses and unmapped addresses cannot be changed by a write. The FIFOs, the arbitration and the formatting datapath sit outside this block.

Top module: `chan_csr_bank`

## Requirements
- R1: While rst_n is low, every channel has enable 0, priority 2'b11 and length code 0 (packet length 4), and bus_rdata is zero.
- R2: A write command (bus_cmd = 2'b10) to control offset 0x00, 0x04 or 0x08 (channels 0, 1, 2) updates that channel's outputs on the same clock edge, using the address and data of that cycle. No other channel changes.
- R3: Control field positions: bit 0 is enable, bits 2:1 are priority and bits 5:3 are the length code. A read of the control register returns the written value of these fields in the same positions.
- R4: Control bits 31:6 are reserved. They read as zero whatever is written to them.
- R5: Length codes 0, 1, 2 and 3 drive packet lengths of 4, 8, 16 and 32 on ch_pkt_len_o. Codes 4 to 7 drive 32.
- R6: A read command (bus_cmd = 2'b01) puts the addressed register on bus_rdata in the following cycle. After any cycle without a read command, bus_rdata is zero.
- R7: Status offsets 0x10, 0x14 and 0x18 (channels 0, 1, 2) read as the channel's 8-bit FIFO free level, sampled in the read cycle, in bits 7:0, with bits 31:8 zero.
- R8: Writes to status offsets or to unmapped offsets change no control register. Reads of unmapped offsets return zero.
- R9: Command codes 2'b00 (idle) and 2'b11 perform no access. They change no register and bring no data onto bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cmd | input | 2 | Command: 00 idle, 01 read, 10 write, 11 no access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fifo_lvl_i | input | 24 | Free level of each channel FIFO, 8 bits per channel, channel 0 in the low bits |
| ch_en_o | output | 3 | Enable of each channel |
| ch_prio_o | output | 6 | Priority of each channel, 2 bits per channel |
| ch_len_code_o | output | 9 | Length code of each channel, 3 bits per channel |
| ch_pkt_len_o | output | 18 | Decoded packet length of each channel, 6 bits per channel |

## Verification
The following properties are checked on every cycle:
- bus_rdata returns to zero after any cycle without a read.
- Bits 31:8 of bus_rdata are never set.
- A control register holds its value unless its own write strobe fires.
- Writes to status or unmapped offsets leave all channel outputs unchanged.
- A status read returns the FIFO level sampled in the read cycle.

Some behaviour can only be shown by the bench's scenarios:
- The field positions and the read-back of written values.
- The packet-length decode of every code.
- The reset values.
- That the idle and no-access codes leave registers and read data alone.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int PRIO_W  = 2;
  localparam int LCODE_W = 3;
  localparam int PLEN_W  = 6;
  localparam int FIELD_W = 1 + PRIO_W + LCODE_W;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_NOP  = 2'b11
  } bus_cmd_e;

  // packed order gives len_code at 5:3, prio at 2:1, en at 0
  typedef struct packed {
    logic [LCODE_W-1:0] len_code;
    logic [PRIO_W-1:0]  prio;
    logic               en;
  } ctrl_fields_t;

  localparam ctrl_fields_t CTRL_RST = '{len_code: '0, prio: 2'b11, en: 1'b0};

  localparam logic [7:0] CTRL_BASE = 8'h00;
  localparam logic [7:0] STAT_BASE = 8'h10;
  localparam int         REG_STEP  = 4;

  function automatic logic [PLEN_W-1:0] len_from_code(logic [LCODE_W-1:0] code);
    if (code > 3'd3) return PLEN_W'(32);
    return PLEN_W'(4) << code;
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ctrl_hit,
  output logic [NUM_CH-1:0] stat_hit,
  output logic [NUM_CH-1:0] ctrl_wr,
  output logic              rd_en,
  output logic              wr_en
);

  bus_cmd_e cmd_e;
  assign cmd_e = bus_cmd_e'(cmd);
  assign rd_en = (cmd_e == CMD_RD);
  assign wr_en = (cmd_e == CMD_WR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(int'(CTRL_BASE) + REG_STEP * i);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(int'(STAT_BASE) + REG_STEP * i);
    assign ctrl_hit[i] = (addr == CTRL_ADDR);
    assign stat_hit[i] = (addr == STAT_ADDR);
    assign ctrl_wr[i]  = wr_en && ctrl_hit[i];
  end

endmodule

// File: rtl/csr_chan_ctrl.sv
module csr_chan_ctrl
  import csr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  ctrl_fields_t wr_val,
  output ctrl_fields_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTRL_RST;
    else if (wr_stb) q <= wr_val;
  end

  // R2: a register changes only on its own strobe
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(q));

  // R1: on leaving reset the register holds its reset value
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == CTRL_RST));

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8
) (
  input  ctrl_fields_t [NUM_CH-1:0]   ctrl_q,
  input  logic [NUM_CH*LVL_W-1:0]     fifo_lvl,
  input  logic [NUM_CH-1:0]           ctrl_hit,
  input  logic [NUM_CH-1:0]           stat_hit,
  output logic [DATA_W-1:0]           rd_value
);

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctrl_hit[i]) rd_value = rd_value | DATA_W'(ctrl_q[i]);
      if (stat_hit[i]) rd_value = rd_value | DATA_W'(fifo_lvl[i*LVL_W +: LVL_W]);
    end
  end

endmodule

// File: rtl/chan_csr_bank.sv
module chan_csr_bank
  import csr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  bus_cmd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_CH*LVL_W-1:0]     fifo_lvl_i,
  output logic [NUM_CH-1:0]           ch_en_o,
  output logic [NUM_CH*PRIO_W-1:0]    ch_prio_o,
  output logic [NUM_CH*LCODE_W-1:0]   ch_len_code_o,
  output logic [NUM_CH*PLEN_W-1:0]    ch_pkt_len_o
);

  logic [NUM_CH-1:0]         ctrl_hit;
  logic [NUM_CH-1:0]         stat_hit;
  logic [NUM_CH-1:0]         ctrl_wr;
  logic                      rd_en;
  logic                      wr_en;
  logic                      any_hit;
  logic [DATA_W-1:0]         rd_value;
  ctrl_fields_t [NUM_CH-1:0] ctrl_q;
  ctrl_fields_t              wr_fields;
  logic                      unused_wbits;

  assign wr_fields    = ctrl_fields_t'(bus_wdata[FIELD_W-1:0]);
  assign unused_wbits = ^bus_wdata[DATA_W-1:FIELD_W];
  assign any_hit      = |{ctrl_hit, stat_hit};

  csr_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .cmd(bus_cmd), .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit),
    .ctrl_wr(ctrl_wr), .rd_en(rd_en), .wr_en(wr_en)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    csr_chan_ctrl u_reg (
      .clk(clk), .rst_n(rst_n), .wr_stb(ctrl_wr[i]), .wr_val(wr_fields), .q(ctrl_q[i])
    );
    assign ch_en_o[i]                        = ctrl_q[i].en;
    assign ch_prio_o[i*PRIO_W +: PRIO_W]     = ctrl_q[i].prio;
    assign ch_len_code_o[i*LCODE_W +: LCODE_W] = ctrl_q[i].len_code;
    assign ch_pkt_len_o[i*PLEN_W +: PLEN_W]  = len_from_code(ctrl_q[i].len_code);

    // R7: status read returns the level sampled in the read cycle
    p_stat_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && stat_hit[i]) |=> (bus_rdata == DATA_W'($past(fifo_lvl_i[i*LVL_W +: LVL_W]))));
  end

  csr_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_mux (
    .ctrl_q(ctrl_q), .fifo_lvl(fifo_lvl_i), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit),
    .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else bus_rdata <= rd_en ? rd_value : '0;
  end

  // R6: bus is quiet after a cycle without a read
  p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (bus_rdata == '0));

  // R4: no register drives bits above the status field
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:LVL_W] == '0);

  // R8: unmapped read returns zero
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_hit) |=> (bus_rdata == '0));

  // R8: write outside the control offsets leaves every output unchanged
  p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|ctrl_hit)) |=> ($stable(ch_en_o) && $stable(ch_prio_o) && $stable(ch_len_code_o)));

endmodule

// File: tb/chan_csr_bank_tb_top.sv
`timescale 1ns/1ps
module chan_csr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [23:0] fifo_lvl_i;
  logic [2:0]  ch_en_o;
  logic [5:0]  ch_prio_o;
  logic [8:0]  ch_len_code_o;
  logic [17:0] ch_pkt_len_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [5:0] exp_ctrl [3];

  always #2 clk = ~clk;

  chan_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_lvl_i(fifo_lvl_i),
    .ch_en_o(ch_en_o), .ch_prio_o(ch_prio_o), .ch_len_code_o(ch_len_code_o),
    .ch_pkt_len_o(ch_pkt_len_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_len(input logic [2:0] code);
    case (code)
      3'd0: return 6'd4;
      3'd1: return 6'd8;
      3'd2: return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cmd = 2'b10; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cmd = 2'b00; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cmd = 2'b01; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_cmd = 2'b00; bus_addr = '0;
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < 3; i++) begin
      check(req, {31'd0, ch_en_o[i]}, {31'd0, exp_ctrl[i][0]});
      check(req, {30'd0, ch_prio_o[2*i +: 2]}, {30'd0, exp_ctrl[i][2:1]});
      check(req, {29'd0, ch_len_code_o[3*i +: 3]}, {29'd0, exp_ctrl[i][5:3]});
      check(req, {26'd0, ch_pkt_len_o[6*i +: 6]}, {26'd0, exp_len(exp_ctrl[i][5:3])});
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) exp_ctrl[i] = 6'b000110;
    @(negedge clk);
    check_outputs("R1 reset fields");
    check("R1 reset rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_write_each;
    logic [31:0] rd;
    logic [5:0] vals [3];
    vals[0] = 6'b001_00_1; vals[1] = 6'b010_01_1; vals[2] = 6'b011_10_1;
    for (int i = 0; i < 3; i++) begin
      do_write(8'(4*i), {26'd0, vals[i]});
      exp_ctrl[i] = vals[i];
      check_outputs("R2 write one channel");
    end
    for (int i = 0; i < 3; i++) begin
      do_read(8'(4*i), rd);
      check("R3 readback fields", rd, {26'd0, exp_ctrl[i]});
      @(negedge clk);
      check("R6 rdata zero after read", bus_rdata, 32'd0);
    end
  endtask

  task automatic t_reserved;
    logic [31:0] rd;
    do_write(8'h04, 32'hFFFF_FFC2);
    exp_ctrl[1] = 6'b000010;
    check_outputs("R4 reserved write");
    do_read(8'h04, rd);
    check("R4 reserved read zero", rd, 32'h0000_0002);
  endtask

  task automatic t_len_decode;
    for (int c = 0; c < 8; c++) begin
      do_write(8'h08, 32'(c << 3));
      exp_ctrl[2] = 6'(c << 3);
      check("R5 length decode", {26'd0, ch_pkt_len_o[12 +: 6]}, {26'd0, exp_len(3'(c))});
    end
  endtask

  task automatic t_status;
    logic [31:0] rd;
    fifo_lvl_i = {8'd63, 8'd1, 8'd0};
    do_read(8'h10, rd); check("R7 status ch0", rd, 32'd0);
    do_read(8'h14, rd); check("R7 status ch1", rd, 32'd1);
    do_read(8'h18, rd); check("R7 status ch2", rd, 32'd63);
    fifo_lvl_i = {8'd200, 8'd64, 8'd255};
    do_read(8'h10, rd); check("R7 status ch0 max", rd, 32'd255);
    do_read(8'h18, rd); check("R7 status ch2 high", rd, 32'd200);
  endtask

  task automatic t_ignored;
    logic [31:0] rd;
    do_write(8'h10, 32'h3F);
    do_write(8'h14, 32'h3F);
    do_write(8'h0C, 32'h3F);
    do_write(8'h01, 32'h3F);
    do_write(8'hFC, 32'h3F);
    check_outputs("R8 ignored writes");
    do_read(8'h0C, rd); check("R8 unmapped read", rd, 32'd0);
    do_read(8'h20, rd); check("R8 unmapped read", rd, 32'd0);
  endtask

  task automatic t_nop_cmds;
    @(negedge clk);
    bus_cmd = 2'b11; bus_addr = 8'h00; bus_wdata = 32'h3F;
    @(negedge clk);
    check("R9 cmd 11 no read data", bus_rdata, 32'd0);
    bus_cmd = 2'b00;
    @(negedge clk);
    check("R9 idle no read data", bus_rdata, 32'd0);
    check_outputs("R9 no access codes");
    bus_wdata = '0;
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    bus_cmd = 2'b01; bus_addr = 8'h00;
    @(negedge clk);
    check("R6 first read", bus_rdata, {26'd0, exp_ctrl[0]});
    bus_addr = 8'h04;
    @(negedge clk);
    check("R6 second read", bus_rdata, {26'd0, exp_ctrl[1]});
    bus_cmd = 2'b00; bus_addr = '0;
    @(negedge clk);
    check("R6 quiet after reads", bus_rdata, 32'd0);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) exp_ctrl[i] = 6'b000110;
    @(negedge clk);
    check_outputs("R1 second reset");
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; bus_cmd = 2'b00; bus_addr = '0; bus_wdata = '0; fifo_lvl_i = '0;
    repeat (3) @(negedge clk);
    t_reset;
    t_write_each;
    t_reserved;
    t_len_decode;
    t_status;
    t_ignored;
    t_nop_cmds;
    t_back_to_back;
    t_reset_again;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule